// File: doc/BRIEF.md
# I2C Target with Word-Accessed Circular Register Files

This block is an I2C bus target that answers one fixed 7-bit device address. It has two circular byte files of 64 bytes each. One captures the bytes a bus controller writes. The other supplies the bytes the controller reads. The local host sees both files only as 32-bit words. It fills the transmit file and drains the receive file through one word port.

Progress is reported by two free-running pointers. The receive pointer counts stored bytes modulo 64. The host finds how many bytes are new by subtracting its previously seen value and masking to six bits. The transmit pointer counts bits shifted onto the bus modulo 512. Its upper six bits give the byte offset being served and its lower three bits give the position within that byte.

A one-cycle interrupt pulse marks the end of each write cycle addressed to this target. That is the only event the host needs: it then either consumes the written bytes or prepares read data. After reset the first transmit word is all ones, so a read with no prior preparation returns 0xFF bytes.

Protocol states:
- `ST_IDLE`: bus free.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: drives the address acknowledge.
- `ST_WR_DATA`: shifts in a write byte.
- `ST_WR_ACK`: acknowledges a stored byte.
- `ST_RD_DATA`: shifts out transmit bits.
- `ST_RD_ACK`: samples the controller's acknowledge.
- `ST_IGNORE`: bus released until the next START or STOP.

Transitions:
- A START moves any state to `ST_ADDR`.
- A STOP moves any state to `ST_IDLE`.
- From `ST_ADDR`, the SCL fall after the 8th bit goes to `ST_ADDR_ACK` if the address matches, else to `ST_IGNORE`.
- `ST_ADDR_ACK` goes to `ST_WR_DATA` or `ST_RD_DATA` by the direction bit, on the next fall.
- `ST_WR_DATA` goes to `ST_WR_ACK` on the fall after 8 bits, and `ST_WR_ACK` returns to `ST_WR_DATA` on the next fall.
- `ST_RD_DATA` goes to `ST_RD_ACK` on the 8th fall.
- `ST_RD_ACK` goes back to `ST_RD_DATA` on an acknowledge, or to `ST_IGNORE` on a not-acknowledge.

Top module: `i2c_wordfile_target`

## Requirements
- R1: An address byte whose upper 7 bits equal 0x50 is acknowledged by driving SDA low during the 9th clock. Any other address leaves SDA released, `sda_oe` at 0, for the rest of that transaction. `sda_oe` changes only while SCL is low.
- R2: The n-th byte written is stored at byte offset (`wr_ptr` before the store) of the receive file. It wraps from offset 63 to 0. Byte offset b lives in word b/4, bits [8*(b%4)+7 : 8*(b%4)].
- R3: `wr_ptr` is 0 after reset and increases by exactly 1, modulo 64, for each stored write byte.
- R4: Every data byte of an addressed write is acknowledged (SDA low in its 9th clock).
- R5: Read data is sent MSB first. Bit `rd_ptr` is bit 7-(`rd_ptr`%8) of the byte at offset `rd_ptr`/8, using the same word and lane mapping as R2. `rd_ptr` increases by 1 per bit sent and wraps from 511 to 0.
- R6: After reset both pointers are 0, transmit word 0 is 0xFFFFFFFF, and all other words of both files are 0.
- R7: `irq_wr_done` pulses high for exactly one cycle when a STOP or repeated START ends an addressed write transaction. It does not pulse for reads or for non-matching addresses.
- R8: With `host_we` high, `host_wdata` is written to transmit word `host_addr` at the clock edge. `host_rdata` shows word `host_addr` of the receive file when `host_sel`=0 and of the transmit file when `host_sel`=1, without delay.
- R9: After the controller answers a read byte with not-acknowledge, the target releases SDA and `rd_ptr` holds until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 pulls SDA low |
| host_we | input | 1 | Host write strobe into the transmit file |
| host_sel | input | 1 | Read select: 0 receive file, 1 transmit file |
| host_addr | input | 4 | Word index |
| host_wdata | input | 32 | Word written into the transmit file |
| host_rdata | output | 32 | Word read from the selected file |
| wr_ptr | output | 6 | Count of bytes stored, modulo 64 |
| rd_ptr | output | 9 | Count of bits sent, modulo 512 |
| irq_wr_done | output | 1 | One-cycle pulse at the end of an addressed write |

## Verification
The bench builds the block with its defaults: device address 0x50, 64-byte files and 4-byte words. With those values a 64-byte write burst wraps the receive pointer back to its start, and 512 read bits wrap the transmit pointer. Both wraps stay well inside the run length. With 16 words per file, the lane mapping at both file ends (word 0 and word 15) is observable through the host port.

// File: rtl/i2cwf_pkg.sv
package i2cwf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } i2cwf_state_e;
endpackage

// File: rtl/i2cwf_bus_edges.sv
module i2cwf_bus_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise  = scl_i & ~scl_q;
        scl_fall  = ~scl_i & scl_q;
        start_det = scl_i & scl_q & sda_q & ~sda_i;
        stop_det  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/i2cwf_files.sv
module i2cwf_files #(
    parameter int FILE_BYTES = 64,
    parameter int WORD_BYTES = 4,
    localparam int WORDS  = FILE_BYTES / WORD_BYTES,
    localparam int WA_W   = $clog2(WORDS),
    localparam int BO_W   = $clog2(FILE_BYTES),
    localparam int LANE_W = $clog2(WORD_BYTES),
    localparam int BI_W   = BO_W + 3,
    localparam int WBITS  = 8 * WORD_BYTES,
    localparam int WB_W   = LANE_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_we,
    input  logic [BO_W-1:0]  rx_off,
    input  logic [7:0]       rx_byte,
    input  logic [BI_W-1:0]  tx_idx,
    output logic             tx_bit,
    input  logic             host_we,
    input  logic             host_sel,
    input  logic [WA_W-1:0]  host_addr,
    input  logic [WBITS-1:0] host_wdata,
    output logic [WBITS-1:0] host_rdata
);
    logic [WBITS-1:0] rx_mem [WORDS];
    logic [WBITS-1:0] tx_mem [WORDS];

    logic [WA_W-1:0] rx_word;
    logic [WB_W-1:0] rx_base;
    logic [BO_W-1:0] tx_off;
    logic [WA_W-1:0] tx_word;
    logic [WB_W-1:0] tx_bitsel;

    always_comb begin
        rx_word   = rx_off[BO_W-1:LANE_W];
        rx_base   = {rx_off[LANE_W-1:0], 3'b000};
        tx_off    = tx_idx[BI_W-1:3];
        tx_word   = tx_off[BO_W-1:LANE_W];
        tx_bitsel = {tx_off[LANE_W-1:0], ~tx_idx[2:0]};
    end

    genvar gw;
    generate
        for (gw = 0; gw < WORDS; gw++) begin : g_word
            localparam logic [WBITS-1:0] TX_INIT = (gw == 0) ? '1 : '0;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rx_mem[gw] <= '0;
                    tx_mem[gw] <= TX_INIT;
                end else begin
                    if (rx_we && rx_word == WA_W'(gw))
                        rx_mem[gw][rx_base +: 8] <= rx_byte;
                    if (host_we && host_addr == WA_W'(gw))
                        tx_mem[gw] <= host_wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        tx_bit     = tx_mem[tx_word][tx_bitsel];
        host_rdata = host_sel ? tx_mem[host_addr] : rx_mem[host_addr];
    end
endmodule

// File: rtl/i2cwf_fsm.sv
module i2cwf_fsm
    import i2cwf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         BO_W     = 6,
    localparam int        BI_W     = BO_W + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic            sda_i,
    input  logic            tx_bit,
    output logic            rx_we,
    output logic [BO_W-1:0] rx_off,
    output logic [7:0]      rx_byte,
    output logic [BO_W-1:0] wr_ptr,
    output logic [BI_W-1:0] rd_ptr,
    output logic            sda_oe,
    output logic            irq
);
    i2cwf_state_e state, nxt;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       rw_q;
    logic       nack_q;
    logic       wsess;
    logic       byte_done;
    logic       addr_hit;

    always_comb begin
        byte_done = scl_fall && (bitcnt == 4'd8);
        addr_hit  = (shreg[7:1] == DEV_ADDR);
    end

    // next-state decision
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) nxt = rw_q ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (byte_done) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && bitcnt == 4'd7) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = nack_q ? ST_IGNORE : ST_RD_DATA;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs from state
    always_comb begin
        sda_oe  = 1'b0;
        rx_we   = 1'b0;
        rx_off  = wr_ptr;
        rx_byte = shreg;
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_DATA:             sda_oe = ~tx_bit;
            ST_WR_DATA:             rx_we  = byte_done && !start_det && !stop_det;
            default:                sda_oe = 1'b0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
            rw_q   <= 1'b0;
            nack_q <= 1'b0;
            wsess  <= 1'b0;
            wr_ptr <= '0;
            rd_ptr <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= (start_det || stop_det) && wsess;
            if (start_det || stop_det) begin
                bitcnt <= '0;
                wsess  <= 1'b0;
            end else begin
                if (scl_rise && (state == ST_ADDR || state == ST_WR_DATA)) begin
                    shreg  <= {shreg[6:0], sda_i};
                    bitcnt <= bitcnt + 4'd1;
                end
                if (scl_rise && state == ST_RD_ACK)
                    nack_q <= sda_i;
                if (state == ST_ADDR && byte_done) begin
                    bitcnt <= '0;
                    rw_q   <= shreg[0];
                    wsess  <= addr_hit && !shreg[0];
                end
                if (rx_we) begin
                    bitcnt <= '0;
                    wr_ptr <= wr_ptr + 1'b1;
                end
                if (state == ST_RD_DATA && scl_fall) begin
                    rd_ptr <= rd_ptr + 1'b1;
                    bitcnt <= (bitcnt == 4'd7) ? 4'd0 : bitcnt + 4'd1;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_wordfile_target.sv
module i2c_wordfile_target #(
    parameter logic [6:0] DEV_ADDR   = 7'h50,
    parameter int         FILE_BYTES = 64,
    parameter int         WORD_BYTES = 4,
    localparam int        WORDS = FILE_BYTES / WORD_BYTES,
    localparam int        WA_W  = $clog2(WORDS),
    localparam int        BO_W  = $clog2(FILE_BYTES),
    localparam int        BI_W  = BO_W + 3,
    localparam int        WBITS = 8 * WORD_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             host_we,
    input  logic             host_sel,
    input  logic [WA_W-1:0]  host_addr,
    input  logic [WBITS-1:0] host_wdata,
    output logic [WBITS-1:0] host_rdata,
    output logic [BO_W-1:0]  wr_ptr,
    output logic [BI_W-1:0]  rd_ptr,
    output logic             irq_wr_done
);
    logic scl_rise, scl_fall, start_det, stop_det;
    logic rx_we, tx_bit;
    logic [BO_W-1:0] rx_off;
    logic [7:0]      rx_byte;

    i2cwf_bus_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cwf_fsm #(.DEV_ADDR(DEV_ADDR), .BO_W(BO_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_i     (sda_i),
        .tx_bit    (tx_bit),
        .rx_we     (rx_we),
        .rx_off    (rx_off),
        .rx_byte   (rx_byte),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .sda_oe    (sda_oe),
        .irq       (irq_wr_done)
    );

    i2cwf_files #(.FILE_BYTES(FILE_BYTES), .WORD_BYTES(WORD_BYTES)) u_files (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_we      (rx_we),
        .rx_off     (rx_off),
        .rx_byte    (rx_byte),
        .tx_idx     (rd_ptr),
        .tx_bit     (tx_bit),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );
endmodule

// File: rtl/i2cwf_checker.sv
module i2cwf_checker #(
    parameter int BO_W = 6,
    parameter int BI_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_i,
    input logic            sda_oe,
    input logic [BO_W-1:0] wr_ptr,
    input logic [BI_W-1:0] rd_ptr,
    input logic            irq_wr_done
);
    p_oe_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    p_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr != $past(wr_ptr)) |-> (wr_ptr == BO_W'($past(wr_ptr) + 1'b1)));

    p_rd_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr != $past(rd_ptr)) |-> (rd_ptr == BI_W'($past(rd_ptr) + 1'b1)));

    p_ptr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr != $past(rd_ptr)) |-> (wr_ptr == $past(wr_ptr)));

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wr_done |=> !irq_wr_done);

    p_irq_scl_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wr_done |-> $past(scl_i));
endmodule

bind i2c_wordfile_target i2cwf_checker #(.BO_W(BO_W), .BI_W(BI_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_oe      (sda_oe),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr),
    .irq_wr_done (irq_wr_done)
);

// File: tb/tb_i2c_wordfile_target.sv
module tb_i2c_wordfile_target;
    localparam int CLK_PERIOD = 10;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_ctl = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [5:0]  wr_ptr;
    logic [8:0]  rd_ptr;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_ctl & ~sda_oe;

    i2c_wordfile_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .irq_wr_done(irq)
    );

    always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

    // {addr7, data8, expected address ack}
    localparam logic [15:0] VEC [4] = '{
        {7'h50, 8'h3C, 1'b1},
        {7'h51, 8'h99, 1'b0},
        {7'h28, 8'h77, 1'b0},
        {7'h50, 8'hA5, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_ctl = b; wt(H);
        scl = 1'b1;  wt(H);
        s = sda_line; wt(H);
        scl = 1'b0;  wt(H);
    endtask

    task automatic bus_start;
        sda_ctl = 1'b1; wt(H);
        scl = 1'b1;     wt(H);
        sda_ctl = 1'b0; wt(H);
        scl = 1'b0;     wt(H);
    endtask

    task automatic bus_stop;
        sda_ctl = 1'b0; wt(H);
        scl = 1'b1;     wt(H);
        sda_ctl = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(nack, s);
    endtask

    task automatic host_rd(input logic sel, input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        host_sel = sel; host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic host_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R7 watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rb;
        logic [31:0] d;
        int irq0;

        wt(4);
        rst_n = 1'b1;
        wt(2);

        // R6 reset state
        chk("R6 wr_ptr", 32'(wr_ptr), 0);
        chk("R6 rd_ptr", 32'(rd_ptr), 0);
        chk("R1 sda_oe idle", 32'(sda_oe), 0);
        host_rd(1'b1, 4'd0, d); chk("R6 tx word0", d, 32'hFFFFFFFF);
        host_rd(1'b1, 4'd1, d); chk("R6 tx word1", d, 0);
        host_rd(1'b0, 4'd0, d); chk("R6 rx word0", d, 0);

        // R6 read with no prior write returns 0xFF
        bus_start;
        send_byte({7'h50, 1'b1}, ack); chk("R1 read addr ack", 32'(ack), 1);
        read_byte(1'b1, rb);           chk("R6 first read byte", 32'(rb), 32'hFF);
        bus_stop;
        chk("R5 rd_ptr after byte", 32'(rd_ptr), 8);
        chk("R7 no irq on read", 32'(irq_cnt), 0);

        // table of single-byte writes
        for (int v = 0; v < 4; v++) begin
            bus_start;
            send_byte({VEC[v][15:9], 1'b0}, ack);
            chk("R1 address ack", 32'(ack), 32'(VEC[v][0]));
            if (VEC[v][0]) begin
                send_byte(VEC[v][8:1], ack);
                chk("R4 data ack", 32'(ack), 1);
            end
            bus_stop;
        end
        chk("R3 wr_ptr after table", 32'(wr_ptr), 2);
        host_rd(1'b0, 4'd0, d); chk("R2 rx word0 lanes", d, 32'h0000A53C);
        chk("R7 irq count table", 32'(irq_cnt), 2);

        // 64-byte burst wraps the receive file
        irq0 = irq_cnt;
        bus_start;
        send_byte({7'h50, 1'b0}, ack);
        for (int k = 0; k < 64; k++) send_byte(8'(8'h80 + k), ack);
        chk("R4 last burst ack", 32'(ack), 1);
        bus_stop;
        chk("R3 wr_ptr wrap", 32'(wr_ptr), 2);
        host_rd(1'b0, 4'd0, d);  chk("R2 wrap word0", d, 32'h8180BFBE);
        host_rd(1'b0, 4'd15, d); chk("R2 word15", d, 32'hBDBCBBBA);
        chk("R7 one irq per burst", 32'(irq_cnt - irq0), 1);

        // host writes the transmit file, controller reads from rd_ptr=8
        host_wr(4'd0, 32'h33221100);
        host_wr(4'd1, 32'h77665544);
        host_wr(4'd15, 32'hDEADBEEF);
        host_rd(1'b1, 4'd1, d); chk("R8 tx readback", d, 32'h77665544);
        irq0 = irq_cnt;
        bus_start;
        send_byte({7'h50, 1'b1}, ack);
        read_byte(1'b0, rb); chk("R5 byte off1", 32'(rb), 32'h11);
        read_byte(1'b0, rb); chk("R5 byte off2", 32'(rb), 32'h22);
        read_byte(1'b0, rb); chk("R5 byte off3", 32'(rb), 32'h33);
        read_byte(1'b1, rb); chk("R5 byte off4", 32'(rb), 32'h44);
        chk("R5 rd_ptr 40", 32'(rd_ptr), 40);
        // R9: clock on after NACK, target must stay released
        for (int i = 0; i < 9; i++) begin
            logic s;
            clk_bit(1'b1, s);
            chk("R9 released after nack", 32'(s), 1);
        end
        chk("R9 rd_ptr held", 32'(rd_ptr), 40);
        bus_stop;
        chk("R7 no irq read", 32'(irq_cnt - irq0), 0);

        // write then repeated START into read
        irq0 = irq_cnt;
        bus_start;
        send_byte({7'h50, 1'b0}, ack);
        send_byte(8'h5A, ack); chk("R4 ack before rs", 32'(ack), 1);
        bus_start;
        chk("R7 irq at repeated start", 32'(irq_cnt - irq0), 1);
        send_byte({7'h50, 1'b1}, ack);
        read_byte(1'b1, rb); chk("R5 byte off5", 32'(rb), 32'h55);
        bus_stop;
        chk("R7 no irq at read stop", 32'(irq_cnt - irq0), 1);
        chk("R3 wr_ptr 3", 32'(wr_ptr), 3);
        host_rd(1'b0, 4'd0, d); chk("R2 offset2 overwrite", d, 32'h815ABFBE);

        // read pointer wrap at 512 bits
        bus_start;
        send_byte({7'h50, 1'b1}, ack);
        for (int i = 0; i < 57; i++) read_byte(1'b0, rb);
        read_byte(1'b0, rb); chk("R5 byte off63", 32'(rb), 32'hDE);
        chk("R5 rd_ptr wrap", 32'(rd_ptr), 0);
        read_byte(1'b1, rb); chk("R5 byte off0 after wrap", 32'(rb), 32'h00);
        bus_stop;
        chk("R5 rd_ptr after wrap", 32'(rd_ptr), 8);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule